// File: doc/BRIEF.md
# Four-Channel Memory Copy Engine

The block is a register-programmed copy engine with four independent channels. Software programs each channel through a 32-bit register port that has one address and separate read and write strobes. Each channel holds a control word, an element count and three 64-bit addresses: source, destination and a chain pointer. The chain pointer is stored and read back only. Each 64-bit address is written as two 32-bit halves.

Writing a control word with its enable bit set queues the channel. The engine then moves N elements of 1, 2, 4 or 8 bytes over a simple memory master port, one element at a time. Each element takes one read request followed by one write request. For each channel, the source and the destination address can each step by the element width or stay fixed.

When a channel finishes, the engine sets that channel's terminal-count flag in a shared status register and clears the channel's enable bit. Software clears status flags by writing ones to them.

Top module: `dma4_engine`

## Requirements
- R1: Channel n owns 8 consecutive register offsets starting at BASE + 8n, in this order: control, count, source high, source low, destination high, destination low, chain high, chain low. Each register reads back the value last written to it.
- R2: Writing a high half replaces bits 63:32 of the stored address and keeps bits 31:0. Writing a low half replaces bits 31:0 and keeps bits 63:32. A high-half read returns bits 63:32.
- R3: A control write with bit 31 set queues the channel, provided bits 15:0 of its count register are nonzero. The transfer then moves exactly that many elements. With a zero count, the engine issues no memory request, sets no status flag and leaves the written control value unchanged.
- R4: The element width in bytes is 1 shifted left by control bits 26:25, and mem_size carries that field during requests. An element travels little-endian in the low bytes of mem_rdata and mem_wdata, and the unused upper bytes of mem_wdata are zero.
- R5: Control bit 23 set makes the source address step by the width after each element. Control bit 24 does the same for the destination address. With a bit clear, that address stays fixed.
- R6: Each element is one read request and then one write request. A request stays asserted, with a stable address, until mem_ready. Read and write requests are never asserted together.
- R7: When channel n completes, status bit 31-n is set and bit 31 of that channel's control word reads 0. All other control bits are kept.
- R8: The status register is at offset BASE + 0x20. A write to it clears every bit that is 1 in the written value and leaves all other bits unchanged.
- R9: When several channels are queued, the lowest-numbered one is started first. A channel that has started runs to completion before any other channel starts.
- R10: A read of an offset outside the channel registers and the status register returns 0. A write to such an offset changes nothing.
- R11: Reset clears all channel registers and the status register to zero, and no memory request is active.
- R12: All 64 address bits are used: the upper bits written through the high-half registers appear unchanged on mem_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | AW | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle that reg_rd is high |
| mem_rd_req | output | 1 | Memory read request |
| mem_wr_req | output | 1 | Memory write request |
| mem_addr | output | 64 | Byte address of the current request |
| mem_size | output | 2 | Element width field (bytes = 1 << mem_size) |
| mem_wdata | output | 64 | Write data, element in the low bytes |
| mem_rdata | input | 64 | Read data, element in the low bytes |
| mem_ready | input | 1 | Completes the current request |

## Verification
The bench builds the engine with a register base of 0x040 instead of the default, which exercises the base subtraction and the out-of-window decode on both sides of the block. It keeps all four channels and the full 16-bit count field. Every status-bit position from 31 down to 28 is therefore observed. Random upper count bits must be ignored. A long transfer on channel 3 has time to collect queued requests from channels 0 and 2, so the service order can be checked. The memory model answers after a random latency and puts random bytes on the unused read lanes. This tests request holding and lane masking.

// File: rtl/dma4_engine.sv
module dma4_engine #(
  parameter int AW = 10,
  parameter logic [AW-1:0] BASE = 10'h100,
  parameter int NCH = 4,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_rd_req,
  output logic          mem_wr_req,
  output logic [63:0]   mem_addr,
  output logic [1:0]    mem_size,
  output logic [63:0]   mem_wdata,
  input  logic [63:0]   mem_rdata,
  input  logic          mem_ready
);
  localparam int CHB = $clog2(NCH);
  localparam int STAT_OFF = 32;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  logic [31:0] ctrl_q [NCH];
  logic [31:0] cnt_q  [NCH];
  logic [63:0] src_q  [NCH];
  logic [63:0] dst_q  [NCH];
  logic [63:0] sg_q   [NCH];
  logic [31:0] stat_q, stat_d;
  logic [NCH-1:0] pend_q;

  st_t            st_q;
  logic [CHB-1:0] act_q, pick;
  logic [CW-1:0]  rem_q;
  logic [63:0]    cs_q, cd_q, buf_q;
  logic [1:0]     wf_q;
  logic           sinc_q, dinc_q;

  wire [AW-1:0]  off    = reg_addr - BASE;
  wire           in_win = reg_addr >= BASE;
  wire           ch_hit = in_win && off < AW'(NCH * 8);
  wire           st_hit = in_win && off == AW'(STAT_OFF);
  wire [CHB-1:0] rch    = off[CHB+2:3];
  wire [2:0]     rsel   = off[2:0];
  wire [63:0]    step   = 64'd1 << wf_q;
  wire [63:0]    lane_mask = {64{1'b1}} >> (7'd64 - (7'd8 << wf_q));
  wire           last   = rem_q <= CW'(1);
  wire           done   = st_q == S_WR && mem_ready && last;

  assign mem_rd_req = st_q == S_RD;
  assign mem_wr_req = st_q == S_WR;
  assign mem_addr   = (st_q == S_WR) ? cd_q : cs_q;
  assign mem_size   = wf_q;
  assign mem_wdata  = buf_q;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend_q[i]) pick = CHB'(i);
  end

  always_comb begin
    stat_d = stat_q;
    if (reg_wr && st_hit) stat_d = stat_d & ~reg_wdata;
    if (done) stat_d[5'd31 - 5'(act_q)] = 1'b1;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd && ch_hit) begin
      case (rsel)
        3'd0: reg_rdata = ctrl_q[rch];
        3'd1: reg_rdata = cnt_q[rch];
        3'd2: reg_rdata = src_q[rch][63:32];
        3'd3: reg_rdata = src_q[rch][31:0];
        3'd4: reg_rdata = dst_q[rch][63:32];
        3'd5: reg_rdata = dst_q[rch][31:0];
        3'd6: reg_rdata = sg_q[rch][63:32];
        default: reg_rdata = sg_q[rch][31:0];
      endcase
    end else if (reg_rd && st_hit) begin
      reg_rdata = stat_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ctrl_q[i] <= '0;
        cnt_q[i]  <= '0;
        src_q[i]  <= '0;
        dst_q[i]  <= '0;
        sg_q[i]   <= '0;
      end
      stat_q <= '0;
      pend_q <= '0;
      st_q   <= S_IDLE;
      act_q  <= '0;
      rem_q  <= '0;
      cs_q   <= '0;
      cd_q   <= '0;
      buf_q  <= '0;
      wf_q   <= '0;
      sinc_q <= 1'b0;
      dinc_q <= 1'b0;
    end else begin
      stat_q <= stat_d;

      case (st_q)
        S_IDLE: if (|pend_q) begin
          act_q        <= pick;
          pend_q[pick] <= 1'b0;
          cs_q         <= src_q[pick];
          cd_q         <= dst_q[pick];
          rem_q        <= cnt_q[pick][CW-1:0];
          wf_q         <= ctrl_q[pick][26:25];
          dinc_q       <= ctrl_q[pick][24];
          sinc_q       <= ctrl_q[pick][23];
          st_q         <= S_RD;
        end
        S_RD: if (mem_ready) begin
          buf_q <= mem_rdata & lane_mask;
          st_q  <= S_WR;
        end
        S_WR: if (mem_ready) begin
          if (sinc_q) cs_q <= cs_q + step;
          if (dinc_q) cd_q <= cd_q + step;
          rem_q <= rem_q - CW'(1);
          if (last) begin
            ctrl_q[act_q][31] <= 1'b0;
            st_q <= S_IDLE;
          end else begin
            st_q <= S_RD;
          end
        end
        default: st_q <= S_IDLE;
      endcase

      if (reg_wr && ch_hit) begin
        case (rsel)
          3'd0: begin
            ctrl_q[rch] <= reg_wdata;
            if (reg_wdata[31] && cnt_q[rch][CW-1:0] != '0) pend_q[rch] <= 1'b1;
          end
          3'd1: cnt_q[rch]        <= reg_wdata;
          3'd2: src_q[rch][63:32] <= reg_wdata;
          3'd3: src_q[rch][31:0]  <= reg_wdata;
          3'd4: dst_q[rch][63:32] <= reg_wdata;
          3'd5: dst_q[rch][31:0]  <= reg_wdata;
          3'd6: sg_q[rch][63:32]  <= reg_wdata;
          default: sg_q[rch][31:0] <= reg_wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma4_engine_sva.sv
module dma4_engine_sva #(
  parameter int AW = 10,
  parameter logic [AW-1:0] BASE = 10'h100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd_req,
  input logic          mem_wr_req,
  input logic          mem_ready,
  input logic [63:0]   mem_addr,
  input logic [1:0]    mem_size,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   stat_q
);
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd_req && mem_wr_req)); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_ready |=> mem_rd_req && $stable(mem_addr) && $stable(mem_size)); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !mem_ready |=> mem_wr_req && $stable(mem_addr) && $stable(mem_size)); // R6
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_req) |-> $past(mem_rd_req && mem_ready)); // R6
  AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == BASE + AW'(32) && reg_wdata == 32'hFFFF_FFFF && !(mem_wr_req && mem_ready)
    |=> stat_q == 32'h0); // R8
endmodule

bind dma4_engine dma4_engine_sva #(.AW(AW), .BASE(BASE)) sva_i (
  .clk(clk), .rst_n(rst_n), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_size(mem_size), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .stat_q(stat_q)
);

// File: tb/dma4_engine_tb_top.sv
module dma4_engine_tb_top;
  localparam int AW = 10;
  localparam logic [AW-1:0] BASE = 10'h040;
  localparam logic [51:0] HI = 52'hA_BCDE_F012_3456;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_rd_req, mem_wr_req, mem_ready = 1'b0;
  logic [63:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [1:0] mem_size;

  int checks = 0, errors = 0;
  int acc_cnt = 0, bad_hi = 0, bad_lane = 0, bad_size = 0;
  logic [1:0] cur_wf = 2'd0;
  logic [7:0] mem_b [4096];
  logic [7:0] ref_b [4096];
  logic [31:0] ctrl_sent [4];

  always #5 clk = ~clk;

  dma4_engine #(.AW(AW), .BASE(BASE), .NCH(4), .CW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_req(mem_rd_req),
    .mem_wr_req(mem_wr_req), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  always @(negedge clk) begin
    mem_ready = 1'b0;
    if (rst_n && (mem_rd_req || mem_wr_req) && ($urandom % 3) != 0) begin
      mem_ready = 1'b1;
      acc_cnt++;
      if (mem_addr[63:12] != HI) bad_hi++;
      if (mem_size != cur_wf) bad_size++;
      if (mem_rd_req) begin
        for (int b = 0; b < 8; b++)
          mem_rdata[8*b +: 8] = (b < (1 << mem_size)) ? mem_b[(int'(mem_addr[11:0]) + b) % 4096] : 8'($urandom);
      end else begin
        for (int b = 0; b < 8; b++) begin
          if (b < (1 << mem_size)) mem_b[(int'(mem_addr[11:0]) + b) % 4096] = mem_wdata[8*b +: 8];
          else if (mem_wdata[8*b +: 8] != 8'h0) bad_lane++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ra(input int ch, input int sel);
    return BASE + AW'(ch * 8 + sel);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_rd = 1'b1;
    #3 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic setup(input int ch, input int so, input int dof, input logic [31:0] cnt);
    logic [63:0] s, d;
    s = {HI, 12'(so)};
    d = {HI, 12'(dof)};
    wr(ra(ch, 1), cnt);
    wr(ra(ch, 2), s[63:32]);
    wr(ra(ch, 3), s[31:0]);
    wr(ra(ch, 4), d[63:32]);
    wr(ra(ch, 5), d[31:0]);
  endtask

  task automatic start(input int ch, input logic [1:0] wf, input bit sai, input bit dai);
    logic [31:0] c;
    c = 32'h8000_0000 | (32'(wf) << 25) | (32'(dai) << 24) | (32'(sai) << 23) | 32'($urandom & 32'hFFFF);
    ctrl_sent[ch] = c;
    wr(ra(ch, 0), c);
  endtask

  task automatic ref_apply(input int so, input int dof, input int n, input logic [1:0] wf, input bit sai, input bit dai);
    logic [7:0] t [8];
    int s, d, w;
    s = so; d = dof; w = 1 << wf;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < w; b++) t[b] = ref_b[s + b];
      for (int b = 0; b < w; b++) ref_b[d + b] = t[b];
      if (sai) s += w;
      if (dai) d += w;
    end
  endtask

  task automatic poll(input int bitn);
    logic [31:0] v;
    v = '0;
    while (!v[bitn]) rd(BASE + AW'(32), v);
  endtask

  task automatic cmp_mem(input string req);
    int mism;
    mism = 0;
    for (int i = 0; i < 4096; i++) if (mem_b[i] != ref_b[i]) mism++;
    chk(mism == 0, req, 64'(mism), 64'd0);
  endtask

  task automatic one_xfer(input int ch, input int so, input int dof, input int n, input logic [15:0] upper,
                          input logic [1:0] wf, input bit sai, input bit dai, input string req);
    logic [31:0] v;
    cur_wf = wf;
    setup(ch, so, dof, {upper, 16'(n)});
    ref_apply(so, dof, n, wf, sai, dai);
    start(ch, wf, sai, dai);
    poll(31 - ch);
    cmp_mem(req);
    rd(ra(ch, 0), v);
    chk(v == (ctrl_sent[ch] & 32'h7FFF_FFFF), "R7 enable cleared, rest kept", 64'(v), 64'(ctrl_sent[ch] & 32'h7FFF_FFFF));
    rd(BASE + AW'(32), v);
    chk(v == (32'h1 << (31 - ch)), "R7 status flag of channel", 64'(v), 64'(32'h1 << (31 - ch)));
    wr(BASE + AW'(32), 32'h1 << (31 - ch));
    rd(BASE + AW'(32), v);
    chk(v == 32'h0, "R8 write-one clears flag", 64'(v), 64'd0);
  endtask

  initial begin
    logic [31:0] v, exp;
    logic [31:0] vals [8];
    int a0;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4096; i++) begin
      mem_b[i] = 8'($urandom);
      ref_b[i] = mem_b[i];
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11: reset values
    a0 = 0;
    for (int o = 0; o <= 32; o++) begin
      rd(BASE + AW'(o), v);
      if (v != 32'h0) a0++;
    end
    chk(a0 == 0, "R11 registers zero after reset", 64'(a0), 64'd0);
    chk(!mem_rd_req && !mem_wr_req, "R11 no request after reset", {62'd0, mem_rd_req, mem_wr_req}, 64'd0);

    // R1 / R2: readback and half replacement
    for (int ch = 0; ch < 4; ch++) begin
      for (int s = 0; s < 8; s++) begin
        vals[s] = $urandom;
        if (s == 0) vals[s][31] = 1'b0;
        wr(ra(ch, s), vals[s]);
      end
      a0 = 0;
      for (int s = 0; s < 8; s++) begin
        rd(ra(ch, s), v);
        if (v != vals[s]) a0++;
      end
      chk(a0 == 0, "R1 channel registers read back", 64'(a0), 64'd0);
      exp = $urandom;
      wr(ra(ch, 3), exp);
      rd(ra(ch, 2), v);
      chk(v == vals[2], "R2 high half kept on low write", 64'(v), 64'(vals[2]));
      rd(ra(ch, 3), v);
      chk(v == exp, "R2 low half replaced", 64'(v), 64'(exp));
      exp = $urandom;
      wr(ra(ch, 6), exp);
      rd(ra(ch, 7), v);
      chk(v == vals[7], "R2 chain low kept on high write", 64'(v), 64'(vals[7]));
    end

    // R3: zero count starts nothing
    a0 = acc_cnt;
    wr(ra(1, 1), 32'hABCD_0000);
    wr(ra(1, 0), 32'h8180_0005);
    repeat (20) @(posedge clk);
    chk(acc_cnt == a0, "R3 zero count issues no request", 64'(acc_cnt - a0), 64'd0);
    rd(BASE + AW'(32), v);
    chk(v == 32'h0, "R3 zero count sets no flag", 64'(v), 64'd0);
    rd(ra(1, 0), v);
    chk(v == 32'h8180_0005, "R3 zero count keeps control", 64'(v), 64'h8180_0005);

    // directed corner cases
    one_xfer(0, 16, 2100, 12, 16'h0000, 2'd3, 1'b1, 1'b1, "R4 width 8 both step");
    one_xfer(1, 40, 2300, 9, 16'h0000, 2'd0, 1'b0, 1'b1, "R5 source fixed width 1");
    one_xfer(2, 77, 2500, 7, 16'h0000, 2'd1, 1'b1, 1'b0, "R5 destination fixed width 2");
    one_xfer(3, 301, 2700, 1, 16'h0000, 2'd2, 1'b1, 1'b1, "R3 single element width 4");
    one_xfer(2, 500, 3000, 3, 16'hFFFF, 2'd2, 1'b1, 1'b1, "R3 upper count bits ignored");

    // random transfers
    for (int k = 0; k < 24; k++) begin
      one_xfer(int'($urandom % 4), int'($urandom % 1500), 2048 + int'($urandom % 1400),
               1 + int'($urandom % 40), 16'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
               "R5 random copy matches model");
    end

    // R9: priority and run to completion
    cur_wf = 2'd3;
    setup(3, 0, 2048, 32'd100);
    setup(0, 1000, 3000, 32'd5);
    setup(2, 1100, 3100, 32'd5);
    ref_apply(0, 2048, 100, 2'd3, 1'b1, 1'b1);
    ref_apply(1000, 3000, 5, 2'd3, 1'b1, 1'b1);
    ref_apply(1100, 3100, 5, 2'd3, 1'b1, 1'b1);
    start(3, 2'd3, 1'b1, 1'b1);
    start(2, 2'd3, 1'b1, 1'b1);
    start(0, 2'd3, 1'b1, 1'b1);
    poll(31);
    rd(BASE + AW'(32), v);
    chk(v[28] == 1'b1, "R9 started channel 3 completed first", 64'(v), 64'h1000_0000);
    chk(v[29] == 1'b0, "R9 channel 0 served before channel 2", 64'(v), 64'h9000_0000);
    poll(29);
    cmp_mem("R9 queued copies all correct");

    // R10: unimplemented offsets
    wr(BASE + AW'(33), 32'hFFFF_FFFF);
    wr(BASE - AW'(1), 32'hFFFF_FFFF);
    rd(BASE + AW'(32), v);
    chk(v == 32'hB000_0000, "R10 stray writes leave status", 64'(v), 64'hB000_0000);
    rd(BASE + AW'(33), v);
    chk(v == 32'h0, "R10 offset 0x21 reads zero", 64'(v), 64'd0);
    rd(BASE - AW'(1), v);
    chk(v == 32'h0, "R10 offset below base reads zero", 64'(v), 64'd0);

    // R8: partial clear
    wr(BASE + AW'(32), 32'h2000_0000);
    rd(BASE + AW'(32), v);
    chk(v == 32'h9000_0000, "R8 only written ones clear", 64'(v), 64'h9000_0000);
    wr(BASE + AW'(32), 32'hFFFF_FFFF);
    rd(BASE + AW'(32), v);
    chk(v == 32'h0, "R8 all flags cleared", 64'(v), 64'd0);

    chk(bad_hi == 0, "R12 upper address bits on mem_addr", 64'(bad_hi), 64'd0);
    chk(bad_size == 0, "R4 mem_size equals width field", 64'(bad_size), 64'd0);
    chk(bad_lane == 0, "R4 unused write lanes zero", 64'(bad_lane), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule